// File: doc/BRIEF.md
# Result Store Sequencer

The result store sequencer is the timing chain that runs once an instruction's execute phase has finished. It writes the result back in up to three steps. First comes an optional memory write of the arithmetic register to the effective address. Next comes an optional write of the arithmetic register into the fast accumulator named by the instruction's 4-bit AC field. Last comes an optional second accumulator write of the MQ register into the next accumulator, wrapping modulo 16.

Each memory operation is issued as a single-cycle request. The sequencer then parks in a wait state. When the memory answers with a done pulse, a set of resume flags decides where the chain picks up again. When the chain ends, the sequencer issues a single-cycle pulse that starts the next major cycle: a key cycle, an instruction cycle, or the console-start path.

The qualifiers and data words are captured when `start` is accepted. The run and key inputs are read only at the final step.

Top module: `store_seq`

## Requirements
- R1: After synchronous reset, `wr_req`, `rw_restart_req`, `go_key`, `go_inst` and `go_console` are 0 and `mem_addr`/`mem_buf` are 0.
- R2: When `start` is accepted with `store_mem`=1, the first write request carries `mem_addr`=`exec_addr` and `mem_buf`=`arith_word`.
- R3: When `start` is accepted with `store_mem`=0 and `pause_done`=1, exactly one `rw_restart_req` is issued, and no write precedes it. `wr_req` and `rw_restart_req` are never high together.
- R4: When `start` is accepted with `store_mem`=0 and `pause_done`=0, no memory request precedes the accumulator decision.
- R5: With `ac_inhibit`=1 no accumulator write is issued; the only possible write is the one from R2.
- R6: With `ac_inhibit`=0, a write is issued with `mem_addr` equal to the zero-extended `ac_field` and `mem_buf`=`arith_word`. It follows any write from R2.
- R7: With `ac_inhibit`=0 and `ac_pair`=1, a further write follows at address (`ac_field`+1) mod 16, upper address bits zero, with `mem_buf`=`mq_word`. `ac_pair` has no effect when `ac_inhibit`=1.
- R8: After each request, no further request is issued until `mem_done` has been seen.
- R9: At the end of the chain, with `run`=1, `go_key` pulses if `exam_dep_pending`=1, and `go_inst` pulses otherwise. With `run`=0 neither pulses. The two never pulse together.
- R10: At the end of the chain `go_console` pulses exactly when `console_key`=1, independent of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the store chain (accepted when idle) |
| store_mem | input | 1 | Write result to the effective address |
| pause_done | input | 1 | Fetch used a read-pause; restart memory cycle |
| ac_inhibit | input | 1 | Suppress accumulator writes |
| ac_pair | input | 1 | Also write MQ to accumulator AC+1 |
| exec_addr | input | AW | Effective address for the memory write |
| arith_word | input | DW | Arithmetic register value |
| mq_word | input | DW | MQ register value |
| ac_field | input | 4 | Accumulator number |
| run | input | 1 | Machine running |
| exam_dep_pending | input | 1 | Examine or deposit key pending |
| console_key | input | 1 | Start, read-in or continue key active |
| mem_done | input | 1 | Memory restart pulse |
| mem_addr | output | AW | Memory address register |
| mem_buf | output | DW | Memory buffer register |
| wr_req | output | 1 | Write request pulse |
| rw_restart_req | output | 1 | Read-write restart request pulse |
| go_key | output | 1 | Start key cycle pulse |
| go_inst | output | 1 | Start instruction cycle pulse |
| go_console | output | 1 | Start console path pulse |

## Verification
A corrupted resume flag shows up at the ports on the next `mem_done`. The chain either skips the accumulator writes, repeats one, or ends early with a premature `go_*` pulse, all within a few cycles of that memory answer. A wrong address or buffer update is visible on the very cycle `wr_req` is high. For that reason, every write is logged with its address and data, and the full ordered list is compared for all sixteen qualifier combinations. The count of restart requests and the exit pulse are checked as well.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
  localparam int AC_BITS = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACDEC, ST_ACWR, ST_POSTAC, ST_PAIR, ST_FINAL
  } seq_state_e;

  typedef enum logic [2:0] {
    DP_HOLD, DP_LOAD_E, DP_CLR, DP_AC, DP_PAIR
  } dp_op_e;

  typedef enum logic [1:0] {
    RS_NONE, RS_ACDEC, RS_POSTAC, RS_FINAL
  } resume_e;
endpackage

// File: rtl/store_resume_flags.sv
module store_resume_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_acdec,
  input  logic set_postac,
  input  logic set_final,
  input  logic clr_acdec,
  input  logic clr_postac,
  input  logic clr_final,
  output logic [2:0] flags,
  output store_seq_pkg::resume_e target
);
  import store_seq_pkg::*;

  logic f_acdec, f_postac, f_final;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_acdec <= 1'b0;
      f_postac <= 1'b0;
      f_final <= 1'b0;
    end else begin
      if (set_acdec) f_acdec <= 1'b1;
      else if (clr_acdec) f_acdec <= 1'b0;
      if (set_postac) f_postac <= 1'b1;
      else if (clr_postac) f_postac <= 1'b0;
      if (set_final) f_final <= 1'b1;
      else if (clr_final) f_final <= 1'b0;
    end
  end

  assign flags = {f_final, f_postac, f_acdec};

  // priority: final, then post-AC-write, then accumulator decision
  always_comb begin
    if (f_final) target = RS_FINAL;
    else if (f_postac) target = RS_POSTAC;
    else if (f_acdec) target = RS_ACDEC;
    else target = RS_NONE;
  end

  // R8: a single resume point is armed at any time
  assert_one_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags));
endmodule

// File: rtl/store_datapath.sv
module store_datapath #(
  parameter int AW = 18,
  parameter int DW = 36
) (
  input  logic clk,
  input  logic rst,
  input  store_seq_pkg::dp_op_e op,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_word,
  input  logic [store_seq_pkg::AC_BITS-1:0] ac_num,
  input  logic [DW-1:0] ac_word,
  input  logic [DW-1:0] ac2_word,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] buf_q
);
  import store_seq_pkg::*;
  localparam int HI = AW - AC_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      buf_q <= '0;
    end else begin
      case (op)
        DP_LOAD_E: begin
          addr <= e_addr;
          buf_q <= e_word;
        end
        DP_CLR: addr <= '0;
        DP_AC: begin
          addr <= addr | {{HI{1'b0}}, ac_num};
          buf_q <= ac_word;
        end
        DP_PAIR: begin
          addr <= {{HI{1'b0}}, addr[AC_BITS-1:0] + AC_BITS'(1)};
          buf_q <= ac2_word;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/store_exit.sv
module store_exit (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic run,
  input  logic exam_dep_pending,
  input  logic console_key,
  output logic go_key,
  output logic go_inst,
  output logic go_console
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go_key <= 1'b0;
      go_inst <= 1'b0;
      go_console <= 1'b0;
    end else begin
      go_key <= fire & run & exam_dep_pending;
      go_inst <= fire & run & ~exam_dep_pending;
      go_console <= fire & console_key;
    end
  end

  // R9: key cycle and instruction cycle are exclusive
  assert_exit_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(go_key && go_inst));
endmodule

// File: rtl/store_seq.sv
module store_seq #(
  parameter int AW = 18,
  parameter int DW = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic store_mem,
  input  logic pause_done,
  input  logic ac_inhibit,
  input  logic ac_pair,
  input  logic [AW-1:0] exec_addr,
  input  logic [DW-1:0] arith_word,
  input  logic [DW-1:0] mq_word,
  input  logic [3:0] ac_field,
  input  logic run,
  input  logic exam_dep_pending,
  input  logic console_key,
  input  logic mem_done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_buf,
  output logic wr_req,
  output logic rw_restart_req,
  output logic go_key,
  output logic go_inst,
  output logic go_console
);
  import store_seq_pkg::*;
  localparam int HI = AW - AC_BITS;

  seq_state_e state, nxt;
  dp_op_e dp_op;
  resume_e target;
  logic [2:0] flags;
  logic set_acdec, set_postac, set_final;
  logic clr_acdec, clr_postac, clr_final;
  logic wr_n, rs_n, fire;
  logic q_inh, q_pair;
  logic [3:0] q_ac;
  logic [DW-1:0] q_arith, q_mq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wr_req <= 1'b0;
      rw_restart_req <= 1'b0;
      q_inh <= 1'b0;
      q_pair <= 1'b0;
      q_ac <= '0;
      q_arith <= '0;
      q_mq <= '0;
    end else begin
      state <= nxt;
      wr_req <= wr_n;
      rw_restart_req <= rs_n;
      if (state == ST_IDLE && start) begin
        q_inh <= ac_inhibit;
        q_pair <= ac_pair;
        q_ac <= ac_field;
        q_arith <= arith_word;
        q_mq <= mq_word;
      end
    end
  end

  always_comb begin
    nxt = state;
    dp_op = DP_HOLD;
    set_acdec = 1'b0; set_postac = 1'b0; set_final = 1'b0;
    clr_acdec = 1'b0; clr_postac = 1'b0; clr_final = 1'b0;
    wr_n = 1'b0; rs_n = 1'b0; fire = 1'b0;
    case (state)
      ST_IDLE:
        if (start) begin
          if (store_mem) begin
            dp_op = DP_LOAD_E; wr_n = 1'b1; set_acdec = 1'b1; nxt = ST_WAIT;
          end else if (pause_done) begin
            rs_n = 1'b1; set_acdec = 1'b1; nxt = ST_WAIT;
          end else nxt = ST_ACDEC;
        end
      ST_WAIT:
        if (mem_done) begin
          case (target)
            RS_FINAL:  nxt = ST_FINAL;
            RS_POSTAC: nxt = ST_POSTAC;
            RS_ACDEC:  nxt = ST_ACDEC;
            default:   nxt = ST_WAIT;
          endcase
        end
      ST_ACDEC: begin
        clr_acdec = 1'b1;
        if (q_inh) nxt = ST_FINAL;
        else begin
          dp_op = DP_CLR; nxt = ST_ACWR;
        end
      end
      ST_ACWR: begin
        dp_op = DP_AC; set_postac = 1'b1; wr_n = 1'b1; nxt = ST_WAIT;
      end
      ST_POSTAC: begin
        clr_postac = 1'b1;
        nxt = q_pair ? ST_PAIR : ST_FINAL;
      end
      ST_PAIR: begin
        dp_op = DP_PAIR; set_final = 1'b1; wr_n = 1'b1; nxt = ST_WAIT;
      end
      ST_FINAL: begin
        clr_final = 1'b1; fire = 1'b1; nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  store_resume_flags flags_i (
    .clk(clk), .rst(rst),
    .set_acdec(set_acdec), .set_postac(set_postac), .set_final(set_final),
    .clr_acdec(clr_acdec), .clr_postac(clr_postac), .clr_final(clr_final),
    .flags(flags), .target(target)
  );

  store_datapath #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rst(rst), .op(dp_op),
    .e_addr(exec_addr), .e_word(arith_word), .ac_num(q_ac),
    .ac_word(q_arith), .ac2_word(q_mq),
    .addr(mem_addr), .buf_q(mem_buf)
  );

  store_exit exit_i (
    .clk(clk), .rst(rst), .fire(fire), .run(run),
    .exam_dep_pending(exam_dep_pending), .console_key(console_key),
    .go_key(go_key), .go_inst(go_inst), .go_console(go_console)
  );

  // R3: write and restart requests are exclusive
  assert_req_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rw_restart_req));

  // R8: no new request while waiting for memory
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !mem_done) |=> !wr_req && !rw_restart_req);

  // R6: accumulator write presents the AC number and arithmetic word
  assert_ac_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && flags[1]) |-> (mem_addr == {{HI{1'b0}}, q_ac}) && (mem_buf == q_arith));

  // R7: second accumulator write stays in fast memory and carries MQ
  assert_pair_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && flags[2]) |-> (mem_addr[AW-1:AC_BITS] == '0) && (mem_buf == q_mq));
endmodule

// File: tb/store_seq_tb_top.sv
module store_seq_tb_top;
  localparam int AW = 18;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, store_mem = 0, pause_done = 0, ac_inhibit = 0, ac_pair = 0;
  logic [AW-1:0] exec_addr = '0;
  logic [DW-1:0] arith_word = '0, mq_word = '0;
  logic [3:0] ac_field = '0;
  logic run = 0, exam_dep_pending = 0, console_key = 0, mem_done = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_buf;
  logic wr_req, rw_restart_req, go_key, go_inst, go_console;

  int checks = 0, errors = 0;
  int nwr = 0, nrs = 0, nkey = 0, ninst = 0, ncons = 0, pend = 0;
  logic [AW-1:0] log_a [0:7];
  logic [DW-1:0] log_d [0:7];
  int first_rs_at = -1;

  always #2 clk = ~clk;

  store_seq #(.AW(AW), .DW(DW)) dut_i (.*);

  // memory responder and event log
  always @(negedge clk) begin
    if (pend > 0) begin
      pend = pend - 1;
      mem_done = (pend == 0);
    end else mem_done = 1'b0;
    if (wr_req) begin
      if (nwr < 8) begin log_a[nwr] = mem_addr; log_d[nwr] = mem_buf; end
      nwr = nwr + 1; pend = 3;
    end
    if (rw_restart_req) begin
      if (first_rs_at < 0) first_rs_at = nwr;
      nrs = nrs + 1; pend = 3;
    end
    if (go_key) nkey = nkey + 1;
    if (go_inst) ninst = ninst + 1;
    if (go_console) ncons = ncons + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic sm, input logic pd, input logic inh,
                          input logic pr, input logic [3:0] ac,
                          input logic rn, input logic ex, input logic ck);
    logic [AW-1:0] ea;
    logic [DW-1:0] aw, mw;
    int k;
    ea = AW'({sm, pd, inh, pr, ac}) | 18'o400000;
    aw = DW'(36'o123400000000) ^ DW'({sm, pd, inh, pr, ac});
    mw = DW'(36'o765000000000) | DW'(ac);
    nwr = 0; nrs = 0; nkey = 0; ninst = 0; ncons = 0; first_rs_at = -1;
    @(negedge clk);
    store_mem = sm; pause_done = pd; ac_inhibit = inh; ac_pair = pr;
    ac_field = ac; exec_addr = ea; arith_word = aw; mq_word = mw;
    run = rn; exam_dep_pending = ex; console_key = ck; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // change inputs after capture: the stored words must be used
    arith_word = '0; mq_word = '0; ac_field = 4'hA;
    repeat (40) @(negedge clk);
    k = 0;
    if (sm) begin
      chk("R2 E address", 64'(log_a[k]), 64'(ea));
      chk("R2 E data", 64'(log_d[k]), 64'(aw));
      k++;
    end
    chk("R3 restart count", 64'(nrs), 64'(!sm && pd));
    if (!sm && pd) chk("R3 restart before writes", 64'(first_rs_at), 64'd0);
    if (!sm && !pd && !inh) begin
      chk("R4 first write is AC", 64'(log_a[0]), 64'(ac));
    end
    if (!inh) begin
      chk("R6 AC address", 64'(log_a[k]), 64'(ac));
      chk("R6 AC data", 64'(log_d[k]), 64'(aw));
      k++;
      if (pr) begin
        chk("R7 AC+1 address", 64'(log_a[k]), 64'(4'(ac + 4'd1)));
        chk("R7 AC+1 data", 64'(log_d[k]), 64'(mw));
        k++;
      end
    end
    chk(inh ? "R5 write count" : "R8 write count", 64'(nwr), 64'(k));
    chk("R9 go_key", 64'(nkey), 64'(rn && ex));
    chk("R9 go_inst", 64'(ninst), 64'(rn && !ex));
    chk("R10 go_console", 64'(ncons), 64'(ck));
  endtask

  task automatic test_reset();
    chk("R1 wr_req", 64'(wr_req), 64'd0);
    chk("R1 rw_restart_req", 64'(rw_restart_req), 64'd0);
    chk("R1 go pulses", 64'({go_key, go_inst, go_console}), 64'd0);
    chk("R1 mem_addr", 64'(mem_addr), 64'd0);
    chk("R1 mem_buf", 64'(mem_buf), 64'd0);
  endtask

  task automatic test_all_qualifiers();
    for (int c = 0; c < 16; c++)
      run_case(c[3], c[2], c[1], c[0], 4'(c * 5 + 3), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_exits();
    run_case(1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0); // R7 wrap, R9 key
    run_case(1'b1, 1'b0, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b1); // R10 console, R9 halted
    run_case(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1); // R9 inst + R10
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_all_qualifiers();
    test_exits();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule